// File: doc/BRIEF.md
# Dual Countdown Timer with Masked Interrupt

This peripheral holds two independent down-counting channels behind a 32-bit word-wide register bus. Each channel keeps a reload divisor, a control register whose source-select field picks one of four externally generated tick enables, and a live count that software can read at any time. When a channel is ticked while its count is zero, it reloads from its divisor and latches a pending bit in a shared raw status register.

Software gates the pending bits with a mask register and clears them through a write-only acknowledge register. A single level interrupt output stays high while any pending bit is also enabled in the mask. A free-running cycle counter is also readable. Clock division is outside the block: it receives one-cycle tick enables for each selectable source rate, nominally about 29.493 MHz, 32 MHz, 32.768 MHz and 100 MHz.

Top module: `dual_tick_timer`

## Requirements
- R1: After a synchronous active-low reset every register reads zero and `irq` is low.
- R2: Channel n sits at byte offset 0x10*n: divisor at +0x0, control at +0x4 (source select in bits [2:0]), count at +0x8; a control write loads the count from the divisor, a divisor write leaves the live count unchanged, and the count register returns the live value.
- R3: Select codes 4, 5, 6 and 7 choose `src_tick[0]`, `[1]`, `[2]` and `[3]`; each selected tick decrements a nonzero count by one, and ticks on other sources have no effect.
- R4: A selected tick while the count is zero reloads the divisor and sets raw status bit n for channel n.
- R5: A select code outside 4 to 7 holds the count still under every tick.
- R6: The mask at 0x84 reads back exactly as written in bits [1:0] with upper bits zero; the masked status at 0x8C reads raw (0x88) AND mask.
- R7: Writing the acknowledge register at 0x90 clears each raw bit written as one and leaves the others; 0x90 always reads zero.
- R8: `irq` is high exactly when some raw bit is set and enabled in the mask.
- R9: The time register at 0x80 increments by one every clock cycle.
- R10: Accesses with `bus_be` other than 4'hF, and accesses to unmapped offsets, write nothing and read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 4 | One-cycle tick enables for select codes 4..7 |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_be | input | 4 | Byte enables; only 4'hF is decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the read strobe |
| irq | output | 1 | Level interrupt request |

## Verification
A corrupted count shows at once on the count register and later as an early, late or missing raw bit when the reload tick arrives. A pending bit that is not cleared or is set spuriously appears at `irq` in the cycle after the offending edge, as soon as the mask enables it. A wrong select decode shows as a count that moves on the wrong source, or stays still, after one tick.

// File: rtl/dtt_pkg.sv
// Package: shared register offsets and sizing for the dual countdown timer.
// Assumes byte offsets, word-aligned, with channel registers strided by 0x10.
package dtt_pkg;
    localparam int ADDR_W     = 8;
    localparam int SEL_W      = 3;
    localparam int SEL_BASE   = 4;
    localparam int NUM_SRC    = 4;
    localparam int CH_STRIDE  = 16;
    localparam int OFF_DIV    = 0;
    localparam int OFF_CTL    = 4;
    localparam int OFF_CNT    = 8;
    localparam logic [ADDR_W-1:0] OFF_TIME  = 8'h80;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h84;
    localparam logic [ADDR_W-1:0] OFF_RAW   = 8'h88;
    localparam logic [ADDR_W-1:0] OFF_MSTAT = 8'h8C;
    localparam logic [ADDR_W-1:0] OFF_ACK   = 8'h90;
endpackage

// File: rtl/dtt_countdown.sv
// Module: one countdown channel. Holds divisor, source select and live count.
// Assumes ctl_we and div_we are never high together (single address per access).
module dtt_countdown #(
    parameter int CNT_W    = 32,
    parameter int SEL_W    = 3,
    parameter int SEL_BASE = 4,
    parameter int NUM_SRC  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               div_we,
    input  logic               ctl_we,
    input  logic [CNT_W-1:0]   div_data,
    input  logic [SEL_W-1:0]   sel_data,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic [CNT_W-1:0]   div_o,
    output logic [SEL_W-1:0]   sel_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               expire_o
);
    logic [CNT_W-1:0] div_q, cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic             tick_en, sel_valid;

    // Pick the tick enable named by the select code; invalid codes give none.
    always_comb begin
        tick_en   = 1'b0;
        sel_valid = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (int'(sel_q) == SEL_BASE + k) begin
                tick_en   = src_tick[k];
                sel_valid = 1'b1;
            end
        end
    end

    assign expire_o = tick_en && !ctl_we && (cnt_q == '0);

    // Divisor and select registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            sel_q <= '0;
        end else begin
            if (div_we) div_q <= div_data;
            if (ctl_we) sel_q <= sel_data;
        end
    end

    // Live count: load on control write, reload at zero, else step down.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (ctl_we)      cnt_q <= div_q;
        else if (tick_en) begin
            if (cnt_q == '0)  cnt_q <= div_q;
            else              cnt_q <= cnt_q - 1'b1;
        end
    end

    assign div_o = div_q;
    assign sel_o = sel_q;
    assign cnt_o = cnt_q;

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (cnt_q == $past(div_q)));
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !ctl_we && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (cnt_q == $past(div_q)));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_valid && !ctl_we) |=> $stable(cnt_q));
endmodule

// File: rtl/dtt_irq_ctrl.sv
// Module: raw pending bits, mask and interrupt level for all channels.
// Assumes expire pulses last one cycle; a same-cycle expiry beats an acknowledge.
module dtt_irq_ctrl #(
    parameter int NUM_TMR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_we,
    input  logic               ack_we,
    input  logic [NUM_TMR-1:0] wbits,
    input  logic [NUM_TMR-1:0] expire,
    output logic [NUM_TMR-1:0] mask_o,
    output logic [NUM_TMR-1:0] raw_o,
    output logic               irq_o
);
    logic [NUM_TMR-1:0] mask_q, raw_q, ack_bits;

    assign ack_bits = ack_we ? wbits : '0;

    // Mask register written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wbits;
    end

    // Pending bits: set by expiry, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~ack_bits) | expire;
    end

    assign irq_o  = |(raw_q & mask_q);
    assign mask_o = mask_q;
    assign raw_o  = raw_q;

    assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire) |=> ((raw_q & $past(expire)) == $past(expire)));
    assert_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && expire == '0) |=> ((raw_q & $past(wbits)) == '0));
    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);
endmodule

// File: rtl/dual_tick_timer.sv
// Module: top of the dual countdown timer; bus decode, read mux, time counter.
// Assumes word accesses only; read data is combinational in the strobe cycle.
module dual_tick_timer #(
    parameter int NUM_TMR = 2,
    parameter int CNT_W   = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  src_tick,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    import dtt_pkg::*;

    logic acc_ok, wr, rd;
    logic [CNT_W-1:0]   div_v [NUM_TMR];
    logic [CNT_W-1:0]   cnt_v [NUM_TMR];
    logic [SEL_W-1:0]   sel_v [NUM_TMR];
    logic [NUM_TMR-1:0] expire, mask_v, raw_v;
    logic [31:0]        tstamp_q;

    assign acc_ok = bus_sel && (bus_be == 4'hF);
    assign wr     = acc_ok && bus_we;
    assign rd     = acc_ok && !bus_we;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
        logic div_we, ctl_we;
        assign div_we = wr && (bus_addr == ADDR_W'(i*CH_STRIDE + OFF_DIV));
        assign ctl_we = wr && (bus_addr == ADDR_W'(i*CH_STRIDE + OFF_CTL));
        dtt_countdown #(
            .CNT_W(CNT_W), .SEL_W(SEL_W), .SEL_BASE(SEL_BASE), .NUM_SRC(NUM_SRC)
        ) u_ch (
            .clk(clk), .rst_n(rst_n),
            .div_we(div_we), .ctl_we(ctl_we),
            .div_data(bus_wdata[CNT_W-1:0]), .sel_data(bus_wdata[SEL_W-1:0]),
            .src_tick(src_tick),
            .div_o(div_v[i]), .sel_o(sel_v[i]), .cnt_o(cnt_v[i]),
            .expire_o(expire[i])
        );
    end

    dtt_irq_ctrl #(.NUM_TMR(NUM_TMR)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .mask_we(wr && bus_addr == OFF_MASK),
        .ack_we(wr && bus_addr == OFF_ACK),
        .wbits(bus_wdata[NUM_TMR-1:0]),
        .expire(expire),
        .mask_o(mask_v), .raw_o(raw_v), .irq_o(irq)
    );

    // Free-running cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) tstamp_q <= '0;
        else        tstamp_q <= tstamp_q + 1'b1;
    end

    // Read multiplexer; unmapped offsets and the acknowledge register give zero.
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            for (int i = 0; i < NUM_TMR; i++) begin
                if (bus_addr == ADDR_W'(i*CH_STRIDE + OFF_DIV)) bus_rdata = 32'(div_v[i]);
                if (bus_addr == ADDR_W'(i*CH_STRIDE + OFF_CTL)) bus_rdata = 32'(sel_v[i]);
                if (bus_addr == ADDR_W'(i*CH_STRIDE + OFF_CNT)) bus_rdata = 32'(cnt_v[i]);
            end
            case (bus_addr)
                OFF_TIME:  bus_rdata = tstamp_q;
                OFF_MASK:  bus_rdata = 32'(mask_v);
                OFF_RAW:   bus_rdata = 32'(raw_v);
                OFF_MSTAT: bus_rdata = 32'(raw_v & mask_v);
                default:   ;
            endcase
        end
    end

    assert_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tstamp_q == $past(tstamp_q) + 1'b1));
    assert_partial_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_be != 4'hF) |=> $stable(mask_v));
endmodule

// File: tb/dual_tick_timer_test.sv
// Bench: scoreboard of expected reads; driver tasks queue items, a monitor
// at the falling edge pops and compares them against the ports.
module dual_tick_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = '0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int errors = 0, checks = 0;
    logic probe = 1'b0;

    typedef struct { bit is_irq; logic [31:0] exp; string tag; } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    dual_tick_timer uut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(logic [31:0] got, logic [31:0] exp, string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Monitor: compare the oldest queued expectation with the ports.
    always @(negedge clk) begin
        if (probe && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.is_irq ? {31'b0, irq} : bus_rdata, it.exp, it.tag);
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk); #1;
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [31:0] e, string tag, logic [3:0] be = 4'hF);
        item_t it;
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 0; bus_addr = a; bus_be = be;
        it.is_irq = 0; it.exp = e; it.tag = tag;
        sb.push_back(it); probe = 1;
        @(posedge clk); #1;
        probe = 0; bus_sel = 0;
    endtask

    task automatic irq_chk(logic e, string tag);
        item_t it;
        @(posedge clk); #1;
        it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
        sb.push_back(it); probe = 1;
        @(posedge clk); #1;
        probe = 0;
    endtask

    task automatic tick(int idx, int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1; src_tick[idx] = 1'b1;
            @(posedge clk); #1; src_tick[idx] = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++; checks++;
        $display("FAIL watchdog: got hang expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] t1, t2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd_chk(8'h08, 0, "R1 t0 count");
        rd_chk(8'h10, 0, "R1 t1 divisor");
        rd_chk(8'h84, 0, "R1 mask");
        rd_chk(8'h88, 0, "R1 raw");
        irq_chk(0, "R1 irq");
        // R9 time register step
        @(posedge clk); #1; bus_sel = 1; bus_we = 0; bus_addr = 8'h80; bus_be = 4'hF;
        @(negedge clk); t1 = bus_rdata;
        repeat (5) @(negedge clk);
        t2 = bus_rdata;
        check(t2 - t1, 5, "R9 time delta");
        @(posedge clk); #1; bus_sel = 0;
        // R2/R3/R4 channel 0 on select 4
        wr(8'h00, 3);
        wr(8'h04, 4);
        rd_chk(8'h08, 3, "R2 load on control");
        rd_chk(8'h04, 4, "R2 control readback");
        tick(0, 1);
        rd_chk(8'h08, 2, "R3 step select 4");
        tick(0, 2);
        rd_chk(8'h08, 0, "R3 reach zero");
        rd_chk(8'h88, 0, "R4 no pending at zero");
        tick(0, 1);
        rd_chk(8'h08, 3, "R4 reload");
        rd_chk(8'h88, 1, "R4 raw bit0");
        irq_chk(0, "R8 masked off");
        rd_chk(8'h8C, 0, "R6 masked status zero");
        // R6/R8 mask
        wr(8'h84, 32'hFFFF_FFFF);
        rd_chk(8'h84, 3, "R6 mask readback");
        rd_chk(8'h8C, 1, "R6 masked status");
        irq_chk(1, "R8 irq high");
        // R7 acknowledge
        wr(8'h90, 2);
        rd_chk(8'h88, 1, "R7 other bit kept");
        wr(8'h90, 1);
        rd_chk(8'h88, 0, "R7 cleared");
        rd_chk(8'h90, 0, "R7 ack reads zero");
        irq_chk(0, "R8 irq low");
        // R3 channel 1 on select 7 ignores other sources
        wr(8'h10, 1);
        wr(8'h14, 7);
        tick(0, 2);
        rd_chk(8'h18, 1, "R3 t1 ignores src0");
        rd_chk(8'h08, 1, "R3 t0 stepped");
        tick(3, 1);
        rd_chk(8'h18, 0, "R3 t1 step select 7");
        tick(3, 1);
        rd_chk(8'h18, 1, "R4 t1 reload");
        rd_chk(8'h88, 2, "R4 raw bit1");
        irq_chk(1, "R8 irq from t1");
        wr(8'h90, 2);
        // R2 divisor write keeps live count
        wr(8'h00, 10);
        rd_chk(8'h08, 1, "R2 live count kept");
        wr(8'h04, 5);
        rd_chk(8'h08, 10, "R2 reload new divisor");
        tick(1, 1);
        rd_chk(8'h08, 9, "R3 step select 5");
        tick(2, 1);
        rd_chk(8'h08, 9, "R3 src2 ignored on select 5");
        // R5 invalid select
        wr(8'h04, 2);
        for (int s = 0; s < 4; s++) tick(s, 1);
        rd_chk(8'h08, 10, "R5 hold select 2");
        wr(8'h04, 0);
        tick(0, 2);
        rd_chk(8'h08, 10, "R5 hold select 0");
        rd_chk(8'h88, 0, "R5 no pending");
        // R10 partial and unmapped accesses
        wr(8'h84, 0, 4'h3);
        rd_chk(8'h84, 3, "R10 partial write ignored");
        rd_chk(8'h84, 0, "R10 partial read zero", 4'h1);
        wr(8'h40, 32'h1234_5678);
        rd_chk(8'h40, 0, "R10 unmapped read");
        rd_chk(8'h0C, 0, "R10 gap read");
        rd_chk(8'h84, 3, "R10 mask untouched");
        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule